// File: doc/BRIEF.md
# Bidirectional Message Mailbox with Sticky Interrupts

The mailbox sits on a simple memory-mapped register bus. Through it an application processor and an I/O coprocessor pass messages to each other in two independent hardware queues. The outbound queue carries messages from the application side to the I/O side. The inbound queue carries them the other way. Both sides use the same register set.

Each message is a 64-bit first word and a 32-bit second word. A sender writes the first word into a per-queue staging register. Writing the second word then commits the whole message. A receiver reads the first word without disturbing the queue. Reading the second word returns the 32-bit payload together with live pointer and occupancy fields, and removes the entry.

Four interrupt causes watch the queues: outbound empty, outbound not-empty, inbound empty and inbound not-empty. Each cause has a two-state latch:
- `CAUSE_IDLE` moves to `CAUSE_HELD` when its condition is seen and no acknowledge is written for that bit.
- `CAUSE_HELD` moves back to `CAUSE_IDLE` only when software writes a 1 to that bit of the acknowledge register.

Each interrupt output is its latch ANDed with its enable bit. Because a latch re-arms from the live condition, a message that arrives while software is servicing the interrupt cannot be missed.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, all enables and latches are 0 and `irq` is 0. Both control registers read bit 17 (empty) = 1 and bit 16 (full) = 0.
- R2: A write to the staging address (0x60 outbound, 0x90 inbound) stores the 64-bit word. A write to the commit address (0x68 / 0x98) pushes {staged word, wdata[31:0]}. The receive first word (0x70 / 0xA0) returns the oldest entry's 64-bit word, and entries leave in arrival order.
- R3: A read of the receive second word (0x78 / 0xA8) on a non-empty queue returns these fields, all taken before the pop:
  - bits 31:0: the payload;
  - bits 56:52: the occupancy;
  - bits 51:48: the free slots, saturated at 15;
  - bits 47:44: the read pointer;
  - bits 43:40: the write pointer;
  - bits 63:57 and 39:32: zero.
- R4: Reading the receive second word pops one entry. Reading the receive first word never pops.
- R5: A queue holds 16 entries and reports full in control bit 16. A commit to a full queue is dropped and leaves its contents unchanged.
- R6: A receive read on an empty queue returns 0 and moves no pointer.
- R7: A cause latch sets on the clock edge after its condition is true. It stays set even after the condition goes away, until that bit is acknowledged.
- R8: Writing 1 to a bit of the acknowledge register (0x4C) clears that latch; 0 bits have no effect. If the condition still holds, the latch sets again one cycle later. A read of 0x4C returns the latches in bits 3:0.
- R9: `irq[i]` equals latch i AND enable bit i. The enable register at 0x48 is written and read in bits 3:0.
- R10: The two queues, their staging registers and their pointers are fully independent.
- R11: The cause bits are mapped as follows:
  - bit 0: outbound empty;
  - bit 1: outbound not-empty;
  - bit 2: inbound empty;
  - bit 3: inbound not-empty.
  The control registers are at 0x50 (outbound) and 0x80 (inbound).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid in the cycle of the access |
| irq | output | 4 | Level interrupt outputs, one per cause |

## Verification
The bench goes after the following corner cases:
- **Fill and overflow.** It fills a queue to 16 and commits once more while full. A design that overwrote the oldest entry or wrapped its count would then return the wrong payload or status.
- **Empty reads.** It reads both receive words on an empty queue. A design that popped anyway would skew its pointers, and the next status fields would be off.
- **Sticky latches.** It lets a latched cause's condition disappear to prove that the latch holds. It acknowledges a cause whose condition is still true to prove that it re-arms one cycle later. A design that acknowledged permanently would lose a message that arrived during service. A design with no latch would drop short events.
- **Pointer wrap and independence.** It wraps the pointers past 15 and interleaves traffic on both queues. A design with shared staging or mis-sized fields would show up in the second-word readback.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MBX_DEPTH = 16;
    localparam int LO_W      = 64;
    localparam int HI_W      = 32;
    localparam int ENTRY_W   = LO_W + HI_W;
    localparam int PTR_W     = $clog2(MBX_DEPTH);
    localparam int CNT_W     = PTR_W + 1;
    localparam int N_QUEUE   = 2;
    localparam int N_CAUSE   = 2 * N_QUEUE;

    localparam int BIT_FULL  = 16;
    localparam int BIT_EMPTY = 17;

    localparam logic [7:0] OFS_ENABLE = 8'h48;
    localparam logic [7:0] OFS_ACK    = 8'h4C;

    // index 0: outbound queue, index 1: inbound queue
    localparam logic [7:0] OFS_CTRL  [N_QUEUE] = '{8'h50, 8'h80};
    localparam logic [7:0] OFS_STAGE [N_QUEUE] = '{8'h60, 8'h90};
    localparam logic [7:0] OFS_PUSH  [N_QUEUE] = '{8'h68, 8'h98};
    localparam logic [7:0] OFS_PEEK  [N_QUEUE] = '{8'h70, 8'hA0};
    localparam logic [7:0] OFS_POP   [N_QUEUE] = '{8'h78, 8'hA8};

    typedef enum logic {
        CAUSE_IDLE = 1'b0,
        CAUSE_HELD = 1'b1
    } cause_state_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 96,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [PW-1:0]    wr_ptr,
    output logic [PW-1:0]    rd_ptr,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbx_cause_latch.sv
module mbx_cause_latch
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic ack,
    output logic held
);
    cause_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAUSE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAUSE_IDLE: if (cond && !ack) state_d = CAUSE_HELD;
            CAUSE_HELD: if (ack)          state_d = CAUSE_IDLE;
            default:                      state_d = CAUSE_IDLE;
        endcase
    end

    always_comb begin
        held = (state_q == CAUSE_HELD);
    end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [63:0] bus_wdata,
    output logic [63:0] bus_rdata,
    output logic [3:0]  irq
);
    logic wr_acc, rd_acc;
    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    logic [N_QUEUE-1:0]            q_full, q_empty;
    logic [N_QUEUE-1:0][CNT_W-1:0] q_cnt;
    logic [63:0] ctrl_word [N_QUEUE];
    logic [63:0] peek_word [N_QUEUE];
    logic [63:0] pop_word  [N_QUEUE];

    for (genvar g = 0; g < N_QUEUE; g++) begin : g_queue
        logic [LO_W-1:0]    stage_q;
        logic [ENTRY_W-1:0] head;
        logic [PTR_W-1:0]   wp, rp;
        logic [CNT_W-1:0]   free_slots;
        logic [3:0]         free_sat;

        always_ff @(posedge clk) begin
            if (!rst_n)                                    stage_q <= '0;
            else if (wr_acc && bus_addr == OFS_STAGE[g])   stage_q <= bus_wdata;
        end

        mbx_fifo #(.DEPTH(MBX_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (wr_acc && bus_addr == OFS_PUSH[g]),
            .push_data ({stage_q, bus_wdata[HI_W-1:0]}),
            .pop       (rd_acc && bus_addr == OFS_POP[g]),
            .head      (head),
            .wr_ptr    (wp),
            .rd_ptr    (rp),
            .count     (q_cnt[g]),
            .full      (q_full[g]),
            .empty     (q_empty[g])
        );

        assign free_slots = CNT_W'(MBX_DEPTH) - q_cnt[g];
        assign free_sat   = (free_slots > CNT_W'(15)) ? 4'hF : free_slots[3:0];

        always_comb begin
            ctrl_word[g]            = '0;
            ctrl_word[g][BIT_FULL]  = q_full[g];
            ctrl_word[g][BIT_EMPTY] = q_empty[g];
        end

        assign peek_word[g] = q_empty[g] ? '0 : head[ENTRY_W-1:HI_W];
        assign pop_word[g]  = q_empty[g] ? '0 :
            {7'd0, q_cnt[g], free_sat, rp, wp, 8'd0, head[HI_W-1:0]};
    end

    // cause bit 0/1: outbound empty / not-empty, 2/3: inbound empty / not-empty
    logic [N_CAUSE-1:0] cause_cond, cause_ack, cause_held, en_q;
    assign cause_cond = {!q_empty[1], q_empty[1], !q_empty[0], q_empty[0]};
    assign cause_ack  = (wr_acc && bus_addr == OFS_ACK) ? bus_wdata[N_CAUSE-1:0] : '0;

    for (genvar c = 0; c < N_CAUSE; c++) begin : g_cause
        mbx_cause_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (cause_cond[c]),
            .ack   (cause_ack[c]),
            .held  (cause_held[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                en_q <= '0;
        else if (wr_acc && bus_addr == OFS_ENABLE) en_q <= bus_wdata[N_CAUSE-1:0];
    end

    assign irq = cause_held & en_q;

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (bus_addr == OFS_ENABLE) bus_rdata = 64'(en_q);
            if (bus_addr == OFS_ACK)    bus_rdata = 64'(cause_held);
            for (int q = 0; q < N_QUEUE; q++) begin
                if (bus_addr == OFS_CTRL[q]) bus_rdata = ctrl_word[q];
                if (bus_addr == OFS_PEEK[q]) bus_rdata = peek_word[q];
                if (bus_addr == OFS_POP[q])  bus_rdata = pop_word[q];
            end
        end
    end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import mbx_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [7:0]                bus_addr,
    input logic [3:0]                ack_bits,
    input logic [63:0]               bus_rdata,
    input logic [3:0]                irq,
    input logic [3:0]                en_q,
    input logic [3:0]                held,
    input logic [N_QUEUE-1:0]        q_full,
    input logic [N_QUEUE-1:0]        q_empty,
    input logic [N_QUEUE-1:0][CNT_W-1:0] q_cnt
);
    logic ack_wr;
    assign ack_wr = bus_sel && bus_wr && bus_addr == OFS_ACK;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt[0] <= CNT_W'(MBX_DEPTH) && q_cnt[1] <= CNT_W'(MBX_DEPTH));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_PUSH[0] && q_full[0])
        |=> (q_full[0] && q_cnt[0] == CNT_W'(MBX_DEPTH)));

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_POP[1] && q_empty[1])
        |-> (bus_rdata == '0));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~en_q) == '0);

    for (genvar c = 0; c < 4; c++) begin : g_chk
        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (held[c] && !(ack_wr && ack_bits[c])) |=> held[c]);

        assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr && ack_bits[c]) |=> !held[c]);
    end
endmodule

bind ipc_mailbox ipc_mailbox_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ack_bits  (bus_wdata[3:0]),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .en_q      (en_q),
    .held      (cause_held),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .q_cnt     (q_cnt)
);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;

    ipc_mailbox dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference model
    logic [95:0] mq [2][$];
    int          m_wp [2];
    int          m_rp [2];
    logic [63:0] m_stage [2];
    logic [3:0]  m_en;
    logic [3:0]  m_lat;

    function automatic logic [7:0] a_ctrl(int q); return q == 0 ? 8'h50 : 8'h80; endfunction
    function automatic logic [7:0] a_stg(int q);  return q == 0 ? 8'h60 : 8'h90; endfunction
    function automatic logic [7:0] a_push(int q); return q == 0 ? 8'h68 : 8'h98; endfunction
    function automatic logic [7:0] a_peek(int q); return q == 0 ? 8'h70 : 8'hA0; endfunction
    function automatic logic [7:0] a_pop(int q);  return q == 0 ? 8'h78 : 8'hA8; endfunction

    function automatic logic [63:0] model_read(logic [7:0] a);
        logic [63:0] r = '0;
        if (a == 8'h48) r = 64'(m_en);
        if (a == 8'h4C) r = 64'(m_lat);
        for (int q = 0; q < 2; q++) begin
            int n = mq[q].size();
            int fr = 16 - n;
            if (a == a_ctrl(q)) begin
                r[17] = (n == 0);
                r[16] = (n == 16);
            end
            if (a == a_peek(q) && n > 0) r = mq[q][0][95:32];
            if (a == a_pop(q) && n > 0) begin
                r[31:0]  = mq[q][0][31:0];
                r[56:52] = 5'(n);
                r[51:48] = fr > 15 ? 4'hF : 4'(fr);
                r[47:44] = 4'(m_rp[q]);
                r[43:40] = 4'(m_wp[q]);
            end
        end
        return r;
    endfunction

    task automatic model_update(bit sel, bit wr, logic [7:0] a, logic [63:0] d);
        logic [3:0] cond, ack;
        cond = {mq[1].size() != 0, mq[1].size() == 0, mq[0].size() != 0, mq[0].size() == 0};
        ack  = (sel && wr && a == 8'h4C) ? d[3:0] : 4'h0;
        m_lat = ~ack & (m_lat | cond);
        if (sel && wr && a == 8'h48) m_en = d[3:0];
        for (int q = 0; q < 2; q++) begin
            if (sel && wr && a == a_stg(q)) m_stage[q] = d;
            if (sel && wr && a == a_push(q) && mq[q].size() < 16) begin
                mq[q].push_back({m_stage[q], d[31:0]});
                m_wp[q] = (m_wp[q] + 1) % 16;
            end
            if (sel && !wr && a == a_pop(q) && mq[q].size() > 0) begin
                void'(mq[q].pop_front());
                m_rp[q] = (m_rp[q] + 1) % 16;
            end
        end
    endtask

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one bus cycle; irq compared every clock
    task automatic step(bit sel, bit wr, logic [7:0] a, logic [63:0] d, string tag);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        check("R7 R8 R9 R11 irq", 64'(irq), 64'(m_lat & m_en));
        if (sel && !wr) check(tag, bus_rdata, model_read(a));
        @(posedge clk);
        model_update(sel, wr, a, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] a, logic [63:0] d); step(1'b1, 1'b1, a, d, "wr"); endtask
    task automatic rd_reg(logic [7:0] a, string tag);     step(1'b1, 1'b0, a, '0, tag); endtask
    task automatic idle();                                step(1'b0, 1'b0, '0, '0, "idle"); endtask

    task automatic send(int q, logic [63:0] lo, logic [31:0] hi);
        wr_reg(a_stg(q), lo);
        wr_reg(a_push(q), {32'hDEAD_BEEF, hi});
    endtask

    task automatic recv(int q, string tag);
        rd_reg(a_peek(q), tag);
        rd_reg(a_pop(q), tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int q = 0; q < 2; q++) begin
            m_wp[q] = 0; m_rp[q] = 0; m_stage[q] = '0;
        end
        m_en = '0; m_lat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq in reset", 64'(irq), 64'h0);
        rst_n = 1'b1;
        // R1: reset state through the registers
        rd_reg(8'h50, "R1 outbound ctrl");
        rd_reg(8'h80, "R1 inbound ctrl");
        rd_reg(8'h48, "R1 enable");
        rd_reg(8'h4C, "R11 cause latches after reset");
        // R9: enable all causes
        wr_reg(8'h48, 64'hF);
        rd_reg(8'h48, "R9 enable readback");
        // R2 R3 R4: three messages outbound
        send(0, 64'h1111_2222_3333_4444, 32'hA0A0_0001);
        send(0, 64'h5555_6666_7777_8888, 32'hA0A0_0002);
        send(0, 64'h9999_AAAA_BBBB_CCCC, 32'hA0A0_0003);
        rd_reg(8'h50, "R5 ctrl not full");
        rd_reg(8'h70, "R4 peek no pop");
        rd_reg(8'h70, "R4 peek twice");
        recv(0, "R2 R3 fifo order");
        recv(0, "R2 R3 second");
        // R7: bit0 held since reset while queue is not empty
        rd_reg(8'h4C, "R7 sticky empty cause");
        recv(0, "R3 last entry");
        // R6: empty reads
        rd_reg(8'h78, "R6 empty pop read");
        rd_reg(8'h70, "R6 empty peek read");
        // R8: ack not-empty while empty -> stays clear; ack empty -> re-arms
        wr_reg(8'h4C, 64'h2);
        rd_reg(8'h4C, "R8 ack cleared not-empty");
        wr_reg(8'h4C, 64'h1);
        rd_reg(8'h4C, "R8 empty re-armed");
        wr_reg(8'h4C, 64'h0);
        rd_reg(8'h4C, "R8 zero ack no effect");
        // R5: fill, overflow, drain with pointer wrap
        for (int i = 0; i < 16; i++) send(0, 64'(i) << 8, 32'hF000_0000 + 32'(i));
        rd_reg(8'h50, "R5 full flag");
        send(0, 64'hBAD, 32'hBAD);
        rd_reg(8'h50, "R5 still full");
        rd_reg(8'h80, "R10 inbound untouched");
        for (int i = 0; i < 16; i++) recv(0, "R5 R3 drain after overflow");
        rd_reg(8'h50, "R5 empty after drain");
        // R10: interleaved traffic on both queues
        send(1, 64'hCAFE_0000_0000_0001, 32'h0BAD_0001);
        send(0, 64'hFACE_0000_0000_0002, 32'h0BAD_0002);
        wr_reg(a_stg(1), 64'h1234_5678_9ABC_DEF0);
        send(0, 64'hFACE_0000_0000_0003, 32'h0BAD_0003);
        wr_reg(a_push(1), 64'h0000_0000_0BAD_0004);
        rd_reg(8'h4C, "R11 all causes");
        recv(1, "R10 inbound first");
        recv(0, "R10 outbound first");
        recv(1, "R10 inbound staged separately");
        rd_reg(8'hA8, "R6 inbound empty pop");
        recv(0, "R10 outbound last");
        // R9: mask outputs, latches keep their state
        wr_reg(8'h48, 64'h5);
        idle();
        wr_reg(8'h4C, 64'hF);
        idle();
        rd_reg(8'h4C, "R8 re-arm after full ack");
        wr_reg(8'h48, 64'h0);
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule